// File: doc/BRIEF.md
# Speculative Segmented Adder with Carry History

The block adds two unsigned operands using a ripple adder cut into equal segments. At each internal cut a predictor decides which carry the upper segment receives. If the operand bit-pairs just below the cut contain a pair with equal bits, the carry there is fixed by that pair alone. The predictor then uses the carry computed in the current cycle, and the cut never costs a cycle. Otherwise the predictor first tries the carry that actually crossed the cut in the previous addition. This guess is held in a one-bit history register per cut. If the guess disagrees with the carry the lower segment now produces, the cut raises its enable. In the next cycle it switches to the live carry. An addition completes in the first cycle in which no counted enable is high, so most additions take one clock. A chain of wrong guesses can take up to one clock per segment.

A caller presents operands with `in_valid` and waits for `in_ready`. This is the only back-pressure point. While an addition is in flight `in_ready` is low, and anything presented then is ignored. The result has no back-pressure. It appears on `out_sum` with a one-cycle `out_done` pulse, together with the number of evaluation clocks in `out_cycles`. Both values hold until the next pulse. A per-addition field `in_approx_k` drops the lowest k cuts from the completion check. Those cuts keep their first-cycle carry, which trades exactness for fewer clocks.

Top module: `seg_spec_adder`

## Requirements
- R1: An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until the cycle in which `out_done` is 1, when it is 1 again. Values presented while `in_ready` is 0 have no effect on any result.
- R2: With `in_approx_k` = 0 the result equals (A + B) mod 2^WIDTH for every operand pair and history state.
- R3: A cut whose checked bit-pairs (the PAIRS bits directly below the cut) include a pair with equal bits never adds a cycle. Operands with equal A and B finish in 1 cycle.
- R4: A cut whose checked pairs all differ first uses the carry that was actually used there by the previous completed addition. Repeating an exact addition therefore takes 1 cycle.
- R5: After reset every stored carry is 0. With WIDTH=32 and SEGS=8, the first addition 0xFFFFFFFF + 0x00000001 takes exactly SEGS cycles and yields 0.
- R6: A cut whose guess differs from its live carry holds back completion and uses the live carry from the next cycle on. `out_cycles` is always between 1 and SEGS.
- R7: With `in_approx_k` = k, cuts 1..k (counted from the least significant cut, cut j lying at bit j*WIDTH/SEGS) are left out of completion and keep their first-cycle carry. The sum and cycle count follow that rule, and every cut's stored carry becomes the carry it used.
- R8: `out_done` is a single-cycle pulse. `out_sum` and `out_cycles` change only on the edge that raises `out_done`.
- R9: After reset `in_ready` is 1, `out_done` is 0, and `out_sum` and `out_cycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Adder idle, offer will be taken |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_approx_k | input | KW | Number of low cuts left out of completion |
| out_done | output | 1 | One-cycle result pulse |
| out_sum | output | WIDTH | Result of last addition |
| out_cycles | output | CW | Evaluation clocks of last addition |

## Verification
Two functions share a cycle here. One is the return of `in_ready` in the done cycle. The other is an offer arriving while the adder is still busy. The bench drives a stray offer with different operands on the clock after each acceptance. The scoreboard result must match the accepted pair only, so a stray that leaked in would corrupt the sum or the count. A second overlap is a correction that changes the live carry of a higher cut within the same cycle. A full carry ripple from reset history exercises this, and it must cost exactly one clock per segment.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } add_state_e;
endpackage

// File: rtl/seg_add_boundary.sv
// Carry predictor for one internal cut: kill detection, history guess,
// switch-to-live after a miss, history refresh on completion.
module seg_add_boundary #(
  parameter int PAIRS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAIRS-1:0] a_lo,
  input  logic [PAIRS-1:0] b_lo,
  input  logic             live_c,
  input  logic             masked,
  input  logic             load,
  input  logic             busy,
  input  logic             commit,
  output logic             used_c,
  output logic             en_raw
);
  logic prop_all;
  logic sel_live_q;
  logic hist_q;

  // all checked pairs differ: the chain may run through this cut
  assign prop_all = &(a_lo ^ b_lo);
  assign en_raw   = prop_all & ~sel_live_q & (hist_q ^ live_c);
  assign used_c   = (prop_all & ~sel_live_q) ? hist_q : live_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_live_q <= 1'b0;
      hist_q     <= 1'b0;
    end else begin
      if (load)
        sel_live_q <= 1'b0;
      else if (busy && !commit && en_raw && !masked)
        sel_live_q <= 1'b1;
      if (commit)
        hist_q <= used_c;
    end
  end
endmodule

// File: rtl/seg_add_ctrl.sv
// Accept / evaluate / complete sequencing and cycle counting.
module seg_add_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          pend,
  output logic          in_ready,
  output logic          load,
  output logic          busy,
  output logic          commit,
  output logic          done,
  output logic [CW-1:0] cycles
);
  import seg_add_pkg::*;

  add_state_e    st_q;
  logic [CW-1:0] cnt_q;

  assign in_ready = (st_q == ST_IDLE);
  assign busy     = (st_q == ST_BUSY);
  assign load     = in_valid & in_ready;
  assign commit   = busy & ~pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done   <= 1'b0;
      cycles <= '0;
    end else begin
      done <= commit;
      unique case (st_q)
        ST_IDLE: if (load) begin
          st_q  <= ST_BUSY;
          cnt_q <= CW'(1);
        end
        ST_BUSY: if (commit) begin
          st_q   <= ST_IDLE;
          cycles <= cnt_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_spec_adder.sv
// Segmented ripple adder with per-cut carry prediction.
module seg_spec_adder #(
  parameter int WIDTH = 32,
  parameter int SEGS  = 8,
  parameter int PAIRS = 1,
  parameter int KW    = $clog2(SEGS),
  parameter int CW    = $clog2(SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [KW-1:0]    in_approx_k,
  output logic             out_done,
  output logic [WIDTH-1:0] out_sum,
  output logic [CW-1:0]    out_cycles
);
  localparam int SEG_W = WIDTH / SEGS;
  localparam int NCUT  = SEGS - 1;

  logic [WIDTH-1:0] a_q, b_q, sum_c;
  logic [KW-1:0]    k_q;
  logic             load, busy, commit;
  logic [NCUT-1:0]  en_vec, mask_vec;
  logic             seg_cin  [SEGS];
  logic             seg_cout [NCUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      k_q     <= '0;
      out_sum <= '0;
    end else begin
      if (load) begin
        a_q <= in_a;
        b_q <= in_b;
        k_q <= in_approx_k;
      end
      if (commit)
        out_sum <= sum_c;
    end
  end

  assign seg_cin[0] = 1'b0;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    localparam int LO  = s * SEG_W;
    localparam int MSB = LO + SEG_W - 1;
    logic [SEG_W-1:0] part;
    assign part = a_q[LO +: SEG_W] + b_q[LO +: SEG_W]
                + {{(SEG_W-1){1'b0}}, seg_cin[s]};
    assign sum_c[LO +: SEG_W] = part;
    if (s < NCUT) begin : g_cout
      // carry into the top bit recovered from its sum bit
      assign seg_cout[s] = (a_q[MSB] & b_q[MSB])
                         | ((a_q[MSB] ^ b_q[MSB]) & (part[SEG_W-1] ^ a_q[MSB] ^ b_q[MSB]));
    end
  end

  for (genvar c = 0; c < NCUT; c++) begin : g_cut
    localparam int POS = (c + 1) * SEG_W;
    localparam logic [KW-1:0] CIDX = KW'(c);
    assign mask_vec[c] = (CIDX < k_q);
    seg_add_boundary #(.PAIRS(PAIRS)) u_cut (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_lo   (a_q[POS-1 -: PAIRS]),
      .b_lo   (b_q[POS-1 -: PAIRS]),
      .live_c (seg_cout[c]),
      .masked (mask_vec[c]),
      .load   (load),
      .busy   (busy),
      .commit (commit),
      .used_c (seg_cin[c+1]),
      .en_raw (en_vec[c])
    );
  end

  seg_add_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .pend     (|(en_vec & ~mask_vec)),
    .in_ready (in_ready),
    .load     (load),
    .busy     (busy),
    .commit   (commit),
    .done     (out_done),
    .cycles   (out_cycles)
  );
endmodule

// File: rtl/seg_spec_adder_chk.sv
module seg_spec_adder_chk #(
  parameter int WIDTH = 32,
  parameter int SEGS  = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_done,
  input logic [WIDTH-1:0] out_sum,
  input logic [CW-1:0]    out_cycles
);
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R1
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_sum) && $stable(out_cycles)));
  // R6
  cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_cycles >= CW'(1) && out_cycles <= CW'(SEGS)));
endmodule

bind seg_spec_adder seg_spec_adder_chk #(.WIDTH(WIDTH), .SEGS(SEGS), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_done   (out_done),
  .out_sum    (out_sum),
  .out_cycles (out_cycles)
);

// File: tb/seg_spec_adder_tb_top.sv
module seg_spec_adder_tb_top;
  localparam int W     = 32;
  localparam int SEGS  = 8;
  localparam int PAIRS = 1;
  localparam int SW    = W / SEGS;
  localparam int KW    = $clog2(SEGS);
  localparam int CW    = $clog2(SEGS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0, in_b = '0;
  logic [KW-1:0] in_approx_k = '0;
  logic          out_done;
  logic [W-1:0]  out_sum;
  logic [CW-1:0] out_cycles;

  always #5 clk = ~clk;

  seg_spec_adder #(.WIDTH(W), .SEGS(SEGS), .PAIRS(PAIRS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_approx_k(in_approx_k),
    .out_done(out_done), .out_sum(out_sum), .out_cycles(out_cycles));

  typedef struct {
    logic [W-1:0] sum;
    int           cyc;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   hist_m [SEGS];
  bit   finished = 0;

  function automatic void check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  // Reference: per-cut rules from the requirements, evaluated cycle by cycle.
  function automatic void ref_add(input logic [W-1:0] a, input logic [W-1:0] b, input int k,
                                  output logic [W-1:0] s, output int cyc);
    bit sel [SEGS];
    bit used [SEGS];
    for (int i = 0; i < SEGS; i++) sel[i] = 0;
    cyc = 0;
    forever begin
      bit c, pend, p;
      bit en_now [SEGS];
      cyc++;
      c = 0; pend = 0;
      for (int g = 0; g < SEGS; g++) begin
        en_now[g] = 0;
        if (g > 0) begin
          p = 1;
          for (int x = 0; x < PAIRS; x++) p &= a[g*SW-1-x] ^ b[g*SW-1-x];
          if (p && !sel[g]) begin
            used[g] = hist_m[g];
            en_now[g] = (hist_m[g] != c);
          end else used[g] = c;
          c = used[g];
          if (en_now[g] && g > k) pend = 1;
        end
        for (int i = g*SW; i < (g+1)*SW; i++) begin
          s[i] = a[i] ^ b[i] ^ c;
          c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
        end
      end
      if (!pend || cyc > 64) break;
      for (int g = 1; g < SEGS; g++) if (en_now[g] && g > k) sel[g] = 1;
    end
    for (int g = 1; g < SEGS; g++) hist_m[g] = used[g];
  endfunction

  // Driver: offers a pair, records expectation, then a stray offer while busy (R1).
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int k,
                      input string tag, input int lit_cyc = -1, input bit lit_exact = 0);
    exp_t e;
    int   mc;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_a = a; in_b = b; in_approx_k = KW'(k);
    ref_add(a, b, k, e.sum, mc);
    if (lit_exact) e.sum = a + b;
    e.cyc = (lit_cyc >= 0) ? lit_cyc : mc;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_a = $urandom; in_b = $urandom; in_approx_k = KW'($urandom);
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor: compares each result pulse with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && out_done && !finished) begin
      if (q.size() == 0) check(0, "R8", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(out_sum == e.sum, e.tag, "sum", longint'(out_sum), longint'(e.sum));
        check(int'(out_cycles) == e.cyc, e.tag, "cycles", longint'(out_cycles), longint'(e.cyc));
        check(in_ready, "R1", "ready in done cycle", longint'(in_ready), 1);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      check(0, "R6", "watchdog expired", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    for (int i = 0; i < SEGS; i++) hist_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9
    check(in_ready == 1, "R9", "ready", longint'(in_ready), 1);
    check(out_done == 0, "R9", "done", longint'(out_done), 0);
    check(out_sum == 0, "R9", "sum", longint'(out_sum), 0);
    check(out_cycles == 0, "R9", "cycles", longint'(out_cycles), 0);
    // R5 / R6: full ripple against zeroed history costs one clock per segment
    send(32'hFFFF_FFFF, 32'h0000_0001, 0, "R5", SEGS, 1);
    // R4: repetition hits the stored carries
    send(32'hFFFF_FFFF, 32'h0000_0001, 0, "R4", 1, 1);
    // R3: equal operands kill every cut
    send(32'h1357_9BDF, 32'h1357_9BDF, 0, "R3", 1, 1);
    send(32'h0F0F_0F0F, 32'h0F0F_0F0F, 0, "R3", 1, 1);
    // R2 / R4: slowly changing stream
    a = 32'h00FF_FFF0; b = 32'h0000_0100;
    for (int i = 0; i < 60; i++) begin
      send(a, b, 0, "R4", -1, 1);
      a = a + W'($urandom_range(0, 3));
      b = b + W'($urandom_range(0, 1));
    end
    // R2: random operands, exact mode
    for (int i = 0; i < 150; i++) send($urandom, $urandom, 0, "R2", -1, 1);
    // R6: mispredicting chains
    send(32'h0000_0000, 32'h0000_0000, 0, "R6", 1, 1);
    send(32'h7FFF_FFFF, 32'h0000_0001, 0, "R6", -1, 1);
    // R7: approximate mode, every mask width
    for (int k = 1; k < SEGS; k++)
      for (int i = 0; i < 12; i++) send($urandom, $urandom, k, "R7");
    send(32'hFFFF_FFFF, 32'h0000_0001, 0, "R7", -1, 1);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule